// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block keeps three state bits for each of a parameterised number of external interrupt lines: enabled, pending and active. Request inputs are active high and may arrive either as short pulses or as held levels. No mode setting picks between them, because any request cycle sets the pending bit and the bit then stays set. Software changes the enable and pending bits through per-line set and clear strobes.

A priority arbiter elsewhere sees the registered pending-and-enabled vector. It reports handler entry with an acknowledge that carries the line number. The handler's exit comes back as a return strobe that also carries the line number. Entry moves a line from pending to active. An active line cannot be taken again until its return arrives. A request that arrives meanwhile leaves the line pending, so it is serviced once more after the return.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every line is disabled, not pending and inactive, and `ready_o` is all zero.
- R2: A request input that is high for a single clock cycle sets that line's pending bit at the next clock edge, even while the line is disabled.
- R3: Once set, a pending bit stays set after the request input returns low, until handler entry or a software clear removes it.
- R4: Several request pulses on a line before its handler entry produce one pending event. After one entry and one return, the line is idle and its pending bit is 0.
- R5: An acknowledge with `ack_valid`=1 and line number `ack_id` is accepted only if that line is pending, enabled and inactive. An accepted acknowledge clears pending and sets active at the next edge. Any other acknowledge changes nothing.
- R6: An acknowledge for an active line is ignored. A return strobe with `ret_valid`=1 and line number `ret_id` clears that line's active bit at the next edge.
- R7: A request that arrives while a line is active sets its pending bit, and the line can be taken again after its return.
- R8: While a line's request input is held high, its pending bit remains set after a software clear, after handler entry and after a return.
- R9: A line that becomes pending while disabled appears in `ready_o` once it is enabled, and can then be taken.
- R10: The `pend_set` strobe bit sets a line's pending bit and the `pend_clr` bit clears it. Clearing it before handler entry cancels the request, and a later acknowledge for the line is ignored.
- R11: A request in the same cycle as a software pending clear, or as handler entry, leaves the pending bit set. A software pending set in the same cycle as a clear also leaves it set.
- R12: `ready_o` bit i equals the AND of line i's pending and enable bits as they stood one clock cycle earlier.
- R13: The `en_set` bit enables a line and the `en_clr` bit disables it. When both are asserted in the same cycle, the line ends up enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | N | Active-high request per line, pulse or level |
| en_set | input | N | Per-line strobe that sets the enable bit |
| en_clr | input | N | Per-line strobe that clears the enable bit |
| pend_set | input | N | Per-line strobe that sets the pending bit |
| pend_clr | input | N | Per-line strobe that clears the pending bit |
| ack_valid | input | 1 | Handler entry strobe |
| ack_id | input | IDW | Line number of the handler entry |
| ret_valid | input | 1 | Handler return strobe |
| ret_id | input | IDW | Line number of the return |
| enable_o | output | N | Enable bits |
| pending_o | output | N | Pending bits |
| active_o | output | N | Active bits |
| ready_o | output | N | Registered AND of pending and enable |

## Verification
Single-cycle pulses on a disabled line show that capture does not depend on the enable bit. A burst of pulses before entry shows that pulses collapse into one event rather than being counted. Requests held high across a software clear, across entry and across return show that a level source overrides every clear path, while a pulse that lands during the active period shows re-pending without that override. Acknowledges aimed at active, cancelled or disabled lines show that entry is refused in each case. Same-cycle collisions of request with clear, and of set with clear, show which source wins.

// File: rtl/irq_tracker_pkg.sv
package irq_tracker_pkg;

  // Next pending bit: a request or software set always wins over a clear.
  function automatic logic pend_next(input logic cur, input logic req,
                                     input logic sw_set, input logic sw_clr,
                                     input logic taken);
    logic keep;
    keep = cur & ~sw_clr & ~taken;
    return req | sw_set | keep;
  endfunction

  // Next enable bit: set wins over clear.
  function automatic logic en_next(input logic cur, input logic sw_set,
                                   input logic sw_clr);
    return sw_set | (cur & ~sw_clr);
  endfunction

  // Next active bit: entry sets, return clears.
  function automatic logic act_next(input logic cur, input logic taken,
                                    input logic returned);
    return taken | (cur & ~returned);
  endfunction

  // Entry is accepted only for a pending, enabled, inactive line.
  function automatic logic can_take(input logic pend, input logic en,
                                    input logic act);
    return pend & en & ~act;
  endfunction

endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           valid,
  input  logic [IDW-1:0] id,
  output logic [N-1:0]   hit
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = valid && (id == IDW'(i));
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tracker_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en_s,
  input  logic en_c,
  input  logic pd_s,
  input  logic pd_c,
  input  logic ack_hit,
  input  logic ret_hit,
  output logic enable_q,
  output logic pending_q,
  output logic active_q,
  output logic take_ev
);
  assign take_ev = ack_hit & can_take(pending_q, enable_q, active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      pending_q <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      enable_q  <= en_next(enable_q, en_s, en_c);
      pending_q <= pend_next(pending_q, req, pd_s, pd_c, take_ev);
      active_q  <= act_next(active_q, take_ev, ret_hit);
    end
  end
endmodule

// File: rtl/irq_ready_reg.sv
module irq_ready_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pending,
  input  logic [N-1:0] enable,
  output logic [N-1:0] ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= '0;
    else        ready <= pending & enable;
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_req,
  input  logic [N-1:0]   en_set,
  input  logic [N-1:0]   en_clr,
  input  logic [N-1:0]   pend_set,
  input  logic [N-1:0]   pend_clr,
  input  logic           ack_valid,
  input  logic [IDW-1:0] ack_id,
  input  logic           ret_valid,
  input  logic [IDW-1:0] ret_id,
  output logic [N-1:0]   enable_o,
  output logic [N-1:0]   pending_o,
  output logic [N-1:0]   active_o,
  output logic [N-1:0]   ready_o
);
  // Named internal events, observed by the checker.
  logic [N-1:0] ack_hit;
  logic [N-1:0] ret_hit;
  logic [N-1:0] take_vec;

  irq_id_decode #(.N(N), .IDW(IDW)) u_ack_dec (
    .valid(ack_valid), .id(ack_id), .hit(ack_hit)
  );
  irq_id_decode #(.N(N), .IDW(IDW)) u_ret_dec (
    .valid(ret_valid), .id(ret_id), .hit(ret_hit)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    irq_line_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (irq_req[i]),
      .en_s     (en_set[i]),
      .en_c     (en_clr[i]),
      .pd_s     (pend_set[i]),
      .pd_c     (pend_clr[i]),
      .ack_hit  (ack_hit[i]),
      .ret_hit  (ret_hit[i]),
      .enable_q (enable_o[i]),
      .pending_q(pending_o[i]),
      .active_q (active_o[i]),
      .take_ev  (take_vec[i])
    );
  end

  irq_ready_reg #(.N(N)) u_ready (
    .clk(clk), .rst_n(rst_n), .pending(pending_o), .enable(enable_o),
    .ready(ready_o)
  );
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_req,
  input logic [N-1:0] pend_clr,
  input logic [N-1:0] enable_o,
  input logic [N-1:0] pending_o,
  input logic [N-1:0] active_o,
  input logic [N-1:0] ready_o,
  input logic [N-1:0] take_vec,
  input logic [N-1:0] ret_hit
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert ((enable_o | pending_o | active_o | ready_o) == '0);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    req_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |=> pending_o[i]);
    // R11
    req_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && (pend_clr[i] || take_vec[i])) |=> pending_o[i]);
    // R5
    entry_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_vec[i] && !irq_req[i]) |=> (active_o[i] && !pending_o[i]));
    // R6
    entry_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_vec[i] |-> (!active_o[i] && pending_o[i] && enable_o[i]));
    // R6
    return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit[i] && !take_vec[i]) |=> !active_o[i]);
    // R6
    active_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o[i] && !ret_hit[i]) |=> active_o[i]);
    // R12
    ready_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o[i] && enable_o[i]) |=> ready_o[i]);
  end
endmodule

bind irq_state_tracker irq_state_tracker_chk #(.N(N)) u_chk (.*);

// File: tb/irq_state_tracker_test.sv
`timescale 1ns/1ps
module irq_state_tracker_test;
  localparam int N   = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, en_set = '0, en_clr = '0, pend_set = '0, pend_clr = '0;
  logic ack_valid = 1'b0, ret_valid = 1'b0;
  logic [IDW-1:0] ack_id = '0, ret_id = '0;
  logic [N-1:0] enable_o, pending_o, active_o, ready_o;

  always #2 clk = ~clk;

  irq_state_tracker #(.N(N), .IDW(IDW)) uut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           due;
    string        tag;
    logic [N-1:0] en, pd, ac, rd;
  } exp_t;
  exp_t q[$];

  // bench reference state, updated from the requirements
  logic [N-1:0] m_en = '0, m_pd = '0, m_ac = '0, m_rd = '0;

  task automatic step(input string tag,
                      input logic [N-1:0] req = '0, input logic [N-1:0] es = '0,
                      input logic [N-1:0] ec = '0, input logic [N-1:0] ps = '0,
                      input logic [N-1:0] pc = '0,
                      input logic av = 1'b0, input int aid = 0,
                      input logic rv = 1'b0, input int rid = 0);
    exp_t e;
    logic [N-1:0] acc, rt;
    @(negedge clk);
    irq_req = req; en_set = es; en_clr = ec; pend_set = ps; pend_clr = pc;
    ack_valid = av; ack_id = IDW'(aid); ret_valid = rv; ret_id = IDW'(rid);
    acc = '0; rt = '0;
    if (av && m_pd[aid] && m_en[aid] && !m_ac[aid]) acc[aid] = 1'b1;
    if (rv) rt[rid] = 1'b1;
    m_rd = m_pd & m_en;
    m_pd = req | ps | (m_pd & ~pc & ~acc);
    m_en = es | (m_en & ~ec);
    m_ac = acc | (m_ac & ~rt);
    e.due = cyc + 1; e.tag = tag; e.en = m_en; e.pd = m_pd; e.ac = m_ac; e.rd = m_rd;
    q.push_back(e);
  endtask

  // monitor: compares each expected item one cycle after its stimulus
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (enable_o !== e.en || pending_o !== e.pd || active_o !== e.ac || ready_o !== e.rd) begin
        errors++;
        $display("FAIL %s en/pd/ac/rd actual %h/%h/%h/%h expected %h/%h/%h/%h",
                 e.tag, enable_o, pending_o, active_o, ready_o, e.en, e.pd, e.ac, e.rd);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ((enable_o | pending_o | active_o | ready_o) !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual %h/%h/%h/%h expected 0",
               enable_o, pending_o, active_o, ready_o);
    end
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle after reset");
    // R2 pulse on disabled line 0, R3 stays after drop
    step("R2 pulse capture", .req(8'h01));
    step("R3 sticky pending");
    step("R3 sticky pending again");
    // R9 enable line 0, R13 enable strobe, R12 ready lag
    step("R9 enable after pending", .es(8'h01));
    step("R12 ready follows");
    // R5 entry
    step("R5 entry", .av(1), .aid(0));
    // R6 ack while active ignored, after a new pulse (R7)
    step("R7 pulse while active", .req(8'h01));
    step("R6 ack on active ignored", .av(1), .aid(0));
    step("R6 return", .rv(1), .rid(0));
    step("R7 taken again", .av(1), .aid(0));
    step("R6 second return", .rv(1), .rid(0));
    // R4 burst on disabled line 1
    step("R4 pulse a", .req(8'h02));
    step("R4 gap");
    step("R4 pulse b", .req(8'h02));
    step("R4 pulse c", .req(8'h02));
    step("R13 set and clear together", .es(8'h02), .ec(8'h02));
    step("R4 single entry", .av(1), .aid(1));
    step("R4 return", .rv(1), .rid(1));
    step("R4 idle after service");
    step("R5 ack on non-pending ignored", .av(1), .aid(1));
    // R8 held level on line 2
    step("R8 level start", .req(8'h04), .es(8'h04));
    step("R11 request beats clear", .req(8'h04), .pc(8'h04));
    step("R11 request beats entry", .req(8'h04), .av(1), .aid(2));
    step("R8 level during active", .req(8'h04));
    step("R8 re-pend after return", .req(8'h04), .rv(1), .rid(2));
    step("R8 level drops");
    step("R8 entry again", .av(1), .aid(2));
    step("R8 return", .rv(1), .rid(2));
    // R10 software set then clear cancels, line 3
    step("R10 software set", .ps(8'h08));
    step("R10 software clear", .pc(8'h08));
    step("R13 enable line 3", .es(8'h08));
    step("R10 ack on cancelled ignored", .av(1), .aid(3));
    step("R11 set beats clear", .ps(8'h08), .pc(8'h08));
    step("R13 disable line 3", .ec(8'h08));
    step("R5 ack on disabled ignored", .av(1), .aid(3));
    step("R12 ready drops");
    step("R12 settle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule